// File: doc/BRIEF.md
# Single-Bank Row-Buffer Command Sequencer

This block sits between a memory scheduler and one DRAM bank. It takes one read or write request at a time, each naming a row and a column, and turns it into the command sequence the bank needs: activate, column read or write, and precharge. It keeps its own record of whether the bank's row buffer holds a row and which one. Each request is sorted into one of three kinds. A hit targets the row that is already open. A closed access finds no open row. A conflict finds a different row open.

Two row-buffer policies are supported, selected per request by an input. The open policy leaves the row in the buffer after the column command. The closed policy precharges straight after the column command, unless the requester says that the next queued request targets the same row. The sequencer holds each command back until its spacing rules allow it: activate to column, precharge to activate, activate to activate, and write to read. It drives one command per cycle and a no-operation code when it has nothing to issue.

Top module: `bank_cmd_seq`

## Requirements
- R1: After reset `req_ready` is 1 and `cmd_code` is NOP. The bank is treated as precharged, so the first access after any reset starts with an activate, even if a row was open before that reset.
- R2: Command codes on `cmd_code` are NOP=0, ACT=1, RD=2, WR=3, PRE=4. `cmd_row` carries the request row on ACT, RD and WR. `cmd_col` carries the request column on RD and WR. Both fields are zero on NOP and PRE.
- R3: A request to the row that is currently open issues only the column command: RD for a read, WR for a write.
- R4: A request to a precharged bank issues ACT and then the column command.
- R5: A request to a bank holding a different row issues PRE, then ACT of the new row, then the column command. ACT is never issued while a row is open.
- R6: Under the closed policy (`policy_closed`=1), a PRE follows the column command unless `req_same_row` was 1 when the request was accepted, in which case the row stays open. Under the open policy (`policy_closed`=0), the row stays open and `req_same_row` has no effect.
- R7: A column command comes at least TRCD cycles after the ACT that opened its row. When nothing else delays it, it comes exactly TRCD cycles after.
- R8: An ACT comes at least TRP cycles after the preceding PRE. When nothing else delays it, it comes exactly TRP cycles after.
- R9: Two ACTs are at least TRC cycles apart. When nothing else delays the second one, they are exactly TRC cycles apart.
- R10: An RD comes at least TWTR cycles after the latest WR. When nothing else delays it, it comes exactly TWTR cycles after.
- R11: A request is accepted on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle on, while commands are non-NOP, and returns to 1 on the cycle after the final command of the sequence. While the block is idle, `cmd_code` stays NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_closed | input | 1 | 1 selects the closed-row policy, 0 the open-row policy; sampled at accept |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| req_write | input | 1 | 1 = write, 0 = read |
| req_same_row | input | 1 | Next queued request targets the same row; sampled at accept |
| cmd_code | output | 3 | Command issued this cycle (encoding in R2) |
| cmd_row | output | ROW_W | Row field of the command |
| cmd_col | output | COL_W | Column field of the command |

## Verification
The assertions watch every cycle for the four spacing minimums, using their own cycles-since counters. They also check that an activate never lands on an open row, that a column command always targets the row the checker has seen opened, that a command code is legal, and that ready stays low after an accept and whenever a command is issued. What the assertions cannot show is which sequence each access kind and policy should produce. That includes whether the same-row flag keeps a row open, and whether each gap is exactly its minimum and not longer. The bench's request table checks these against the command lists it expects. Its directed reset test shows that the row record is cleared.

// File: rtl/rbseq_pkg.sv
package rbseq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } bank_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_COL,
        ST_CLOSE
    } seq_state_e;

    typedef enum logic [1:0] {
        ACC_HIT,
        ACC_EMPTY,
        ACC_CONFLICT
    } access_kind_e;

    // Timer slots, one per spacing rule
    localparam int unsigned GAP_RCD = 0;
    localparam int unsigned GAP_RP  = 1;
    localparam int unsigned GAP_RC  = 2;
    localparam int unsigned GAP_WTR = 3;
    localparam int unsigned GAP_NUM = 4;

    function automatic access_kind_e classify(input logic is_open, input logic row_match);
        if (!is_open)
            return ACC_EMPTY;
        else if (row_match)
            return ACC_HIT;
        else
            return ACC_CONFLICT;
    endfunction

    function automatic seq_state_e entry_state(input access_kind_e kind);
        case (kind)
            ACC_HIT:   return ST_COL;
            ACC_EMPTY: return ST_ACT;
            default:   return ST_PRE;
        endcase
    endfunction

    function automatic bank_cmd_e column_cmd(input logic is_write);
        return is_write ? CMD_WR : CMD_RD;
    endfunction

endpackage

// File: rtl/rbseq_gap_timer.sv
// Down-counter that holds off a command until GAP cycles after an event.
module rbseq_gap_timer #(
    parameter int unsigned GAP = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic ok
);
    localparam int unsigned CW = (GAP > 1) ? $clog2(GAP) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(GAP - 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (fire)
            remain <= RELOAD;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign ok = (remain == '0);
endmodule

// File: rtl/rbseq_row_tracker.sv
// Records whether the bank holds a row and which one, from issued commands.
module rbseq_row_tracker
    import rbseq_pkg::*;
#(
    parameter int unsigned ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  bank_cmd_e        issue_cmd,
    input  logic [ROW_W-1:0] issue_row,
    output logic             bank_open,
    output logic [ROW_W-1:0] open_row
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bank_open <= 1'b0;
            open_row  <= '0;
        end else begin
            case (issue_cmd)
                CMD_ACT: begin
                    bank_open <= 1'b1;
                    open_row  <= issue_row;
                end
                CMD_PRE: bank_open <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rbseq_fsm.sv
// Accepts a request, picks the entry state from the access kind and steps
// through precharge / activate / column / trailing precharge.
module rbseq_fsm
    import rbseq_pkg::*;
#(
    parameter int unsigned ROW_W = 14,
    parameter int unsigned COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             policy_closed,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_write,
    input  logic             req_same_row,
    input  logic             bank_open,
    input  logic [ROW_W-1:0] open_row,
    input  logic             rcd_ok,
    input  logic             rp_ok,
    input  logic             rc_ok,
    input  logic             wtr_ok,
    output bank_cmd_e        cmd,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col
);
    seq_state_e       state, state_nx;
    logic [ROW_W-1:0] lat_row;
    logic [COL_W-1:0] lat_col;
    logic             lat_write;
    logic             lat_close;
    logic             accept;
    logic             issued;
    access_kind_e     kind;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign kind      = classify(bank_open, open_row == req_row);

    // Command selection: each state waits for the timers that gate it
    always_comb begin
        cmd     = CMD_NOP;
        cmd_row = '0;
        cmd_col = '0;
        case (state)
            ST_PRE, ST_CLOSE: cmd = CMD_PRE;
            ST_ACT: begin
                if (rp_ok && rc_ok) begin
                    cmd     = CMD_ACT;
                    cmd_row = lat_row;
                end
            end
            ST_COL: begin
                if (rcd_ok && (lat_write || wtr_ok)) begin
                    cmd     = column_cmd(lat_write);
                    cmd_row = lat_row;
                    cmd_col = lat_col;
                end
            end
            default: ;
        endcase
    end

    assign issued = (cmd != CMD_NOP);

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (accept) state_nx = entry_state(kind);
            ST_PRE:   if (issued) state_nx = ST_ACT;
            ST_ACT:   if (issued) state_nx = ST_COL;
            ST_COL:   if (issued) state_nx = lat_close ? ST_CLOSE : ST_IDLE;
            ST_CLOSE: if (issued) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            lat_row   <= '0;
            lat_col   <= '0;
            lat_write <= 1'b0;
            lat_close <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                lat_row   <= req_row;
                lat_col   <= req_col;
                lat_write <= req_write;
                lat_close <= policy_closed && !req_same_row;
            end
        end
    end
endmodule

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq
    import rbseq_pkg::*;
#(
    parameter int unsigned ROW_W = 14,
    parameter int unsigned COL_W = 10,
    parameter int unsigned TRCD  = 3,
    parameter int unsigned TRP   = 3,
    parameter int unsigned TRC   = 10,
    parameter int unsigned TWTR  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             policy_closed,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_write,
    input  logic             req_same_row,
    output logic [2:0]       cmd_code,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col
);
    localparam int unsigned GAP_TAB [GAP_NUM] = '{TRCD, TRP, TRC, TWTR};

    bank_cmd_e        cmd;
    logic             bank_open;
    logic [ROW_W-1:0] open_row;
    logic [GAP_NUM-1:0] gap_fire;
    logic [GAP_NUM-1:0] gap_ok;

    assign gap_fire[GAP_RCD] = (cmd == CMD_ACT);
    assign gap_fire[GAP_RP]  = (cmd == CMD_PRE);
    assign gap_fire[GAP_RC]  = (cmd == CMD_ACT);
    assign gap_fire[GAP_WTR] = (cmd == CMD_WR);

    for (genvar g = 0; g < GAP_NUM; g++) begin : g_gap
        rbseq_gap_timer #(
            .GAP(GAP_TAB[g])
        ) u_gap (
            .clk (clk),
            .rst (rst),
            .fire(gap_fire[g]),
            .ok  (gap_ok[g])
        );
    end

    rbseq_row_tracker #(
        .ROW_W(ROW_W)
    ) u_track (
        .clk      (clk),
        .rst      (rst),
        .issue_cmd(cmd),
        .issue_row(cmd_row),
        .bank_open(bank_open),
        .open_row (open_row)
    );

    rbseq_fsm #(
        .ROW_W(ROW_W),
        .COL_W(COL_W)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .policy_closed(policy_closed),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_row      (req_row),
        .req_col      (req_col),
        .req_write    (req_write),
        .req_same_row (req_same_row),
        .bank_open    (bank_open),
        .open_row     (open_row),
        .rcd_ok       (gap_ok[GAP_RCD]),
        .rp_ok        (gap_ok[GAP_RP]),
        .rc_ok        (gap_ok[GAP_RC]),
        .wtr_ok       (gap_ok[GAP_WTR]),
        .cmd          (cmd),
        .cmd_row      (cmd_row),
        .cmd_col      (cmd_col)
    );

    assign cmd_code = cmd;
endmodule

// File: rtl/bank_cmd_seq_chk.sv
module bank_cmd_seq_chk #(
    parameter int unsigned ROW_W = 14,
    parameter int unsigned TRCD  = 3,
    parameter int unsigned TRP   = 3,
    parameter int unsigned TRC   = 10,
    parameter int unsigned TWTR  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [2:0]       cmd_code,
    input logic [ROW_W-1:0] cmd_row
);
    localparam int unsigned MAX_AB = (TRCD > TRP) ? TRCD : TRP;
    localparam int unsigned MAX_CD = (TRC > TWTR) ? TRC : TWTR;
    localparam int unsigned SAT    = ((MAX_AB > MAX_CD) ? MAX_AB : MAX_CD) + 1;

    logic             is_act, is_pre, is_wr, is_rd, is_col;
    int unsigned      since_act, since_pre, since_wr;
    logic             seen_act, seen_pre, seen_wr;
    logic             mon_open;
    logic [ROW_W-1:0] mon_row;

    assign is_act = (cmd_code == 3'd1);
    assign is_rd  = (cmd_code == 3'd2);
    assign is_wr  = (cmd_code == 3'd3);
    assign is_pre = (cmd_code == 3'd4);
    assign is_col = is_rd || is_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= 0; since_pre <= 0; since_wr <= 0;
            seen_act  <= 1'b0; seen_pre <= 1'b0; seen_wr <= 1'b0;
            mon_open  <= 1'b0; mon_row  <= '0;
        end else begin
            since_act <= is_act ? 1 : ((since_act < SAT) ? since_act + 1 : since_act);
            since_pre <= is_pre ? 1 : ((since_pre < SAT) ? since_pre + 1 : since_pre);
            since_wr  <= is_wr  ? 1 : ((since_wr  < SAT) ? since_wr  + 1 : since_wr);
            if (is_act) seen_act <= 1'b1;
            if (is_pre) seen_pre <= 1'b1;
            if (is_wr)  seen_wr  <= 1'b1;
            if (is_act) begin
                mon_open <= 1'b1;
                mon_row  <= cmd_row;
            end else if (is_pre) begin
                mon_open <= 1'b0;
            end
        end
    end

    assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_code <= 3'd4);

    assert_col_on_open_row_R4: assert property (@(posedge clk) disable iff (rst)
        is_col |-> (mon_open && cmd_row == mon_row));

    assert_act_on_closed_R5: assert property (@(posedge clk) disable iff (rst)
        is_act |-> !mon_open);

    assert_act_to_col_R7: assert property (@(posedge clk) disable iff (rst)
        (is_col && seen_act) |-> since_act >= TRCD);

    assert_pre_to_act_R8: assert property (@(posedge clk) disable iff (rst)
        (is_act && seen_pre) |-> since_pre >= TRP);

    assert_act_to_act_R9: assert property (@(posedge clk) disable iff (rst)
        (is_act && seen_act) |-> since_act >= TRC);

    assert_wr_to_rd_R10: assert property (@(posedge clk) disable iff (rst)
        (is_rd && seen_wr) |-> since_wr >= TWTR);

    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_cmd_only_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_code != 3'd0) |-> !req_ready);
endmodule

bind bank_cmd_seq bank_cmd_seq_chk #(
    .ROW_W(ROW_W),
    .TRCD (TRCD),
    .TRP  (TRP),
    .TRC  (TRC),
    .TWTR (TWTR)
) u_bank_cmd_seq_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .cmd_code (cmd_code),
    .cmd_row  (cmd_row)
);

// File: tb/test_bank_cmd_seq.sv
module test_bank_cmd_seq;
    localparam int ROW_W = 14;
    localparam int COL_W = 10;
    localparam int TRCD  = 3;
    localparam int TRP   = 3;
    localparam int TRC   = 10;
    localparam int TWTR  = 4;

    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3, C_PRE = 3'd4;

    // vector: [41] closed policy, [40] write, [39] same-row, [38:25] row,
    // [24:15] col, [14:12] command count, [11:0] four expected commands
    function automatic logic [41:0] mk(input logic pol, input logic wr, input logic same,
                                       input int row, input int col, input int n,
                                       input logic [2:0] c0, input logic [2:0] c1,
                                       input logic [2:0] c2, input logic [2:0] c3);
        return {pol, wr, same, 14'(row), 10'(col), 3'(n), c0, c1, c2, c3};
    endfunction

    localparam int NVEC = 12;
    localparam logic [41:0] VEC [NVEC] = '{
        mk(0, 0, 0, 5, 1, 2, C_ACT, C_RD,  C_NOP, C_NOP),  // R4 empty bank
        mk(0, 0, 0, 5, 2, 1, C_RD,  C_NOP, C_NOP, C_NOP),  // R3 hit read
        mk(0, 1, 0, 5, 3, 1, C_WR,  C_NOP, C_NOP, C_NOP),  // R3 hit write
        mk(0, 0, 0, 5, 4, 1, C_RD,  C_NOP, C_NOP, C_NOP),  // R10 read after write
        mk(0, 0, 0, 9, 0, 3, C_PRE, C_ACT, C_RD,  C_NOP),  // R5 conflict
        mk(1, 1, 0, 9, 7, 2, C_WR,  C_PRE, C_NOP, C_NOP),  // R6 hit then close
        mk(1, 0, 1, 3, 1, 2, C_ACT, C_RD,  C_NOP, C_NOP),  // R6 same-row keeps open
        mk(1, 1, 0, 3, 2, 2, C_WR,  C_PRE, C_NOP, C_NOP),  // R6 hit on kept row
        mk(1, 0, 0, 4, 5, 3, C_ACT, C_RD,  C_PRE, C_NOP),  // R6 closed access
        mk(0, 1, 1, 6, 8, 2, C_ACT, C_WR,  C_NOP, C_NOP),  // R6 flag ignored, R9
        mk(0, 0, 0, 7, 9, 3, C_PRE, C_ACT, C_RD,  C_NOP),  // R6 row 6 stayed open
        mk(1, 0, 0, 8, 2, 4, C_PRE, C_ACT, C_RD,  C_PRE)   // R5 R6 conflict, closed
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             policy_closed = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic             req_write = 1'b0;
    logic             req_same_row = 1'b0;
    logic [2:0]       cmd_code;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;

    bank_cmd_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .TRCD(TRCD), .TRP(TRP), .TRC(TRC), .TWTR(TWTR)
    ) i_bank_cmd_seq (
        .clk(clk), .rst(rst), .policy_closed(policy_closed),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_col(req_col), .req_write(req_write),
        .req_same_row(req_same_row),
        .cmd_code(cmd_code), .cmd_row(cmd_row), .cmd_col(cmd_col)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_ge(input string req, input string what, input int act, input int lim);
        n_chk++;
        if (act < lim) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected >= %0d", req, what, act, lim);
        end
    endtask

    // Spacing monitor on the command port
    int last_act, last_pre, last_wr;
    bit seen_act = 1'b0, seen_pre = 1'b0, seen_wr = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            seen_act = 1'b0; seen_pre = 1'b0; seen_wr = 1'b0;
        end else begin
            if (cmd_code != C_NOP) check_eq("R11", "ready while command", int'(req_ready), 0);
            case (cmd_code)
                C_ACT: begin
                    if (seen_act) check_ge("R9", "act-to-act gap", cyc - last_act, TRC);
                    if (seen_pre) check_ge("R8", "pre-to-act gap", cyc - last_pre, TRP);
                    last_act = cyc; seen_act = 1'b1;
                end
                C_RD: begin
                    if (seen_act) check_ge("R7", "act-to-rd gap", cyc - last_act, TRCD);
                    if (seen_wr)  check_ge("R10", "wr-to-rd gap", cyc - last_wr, TWTR);
                end
                C_WR: begin
                    if (seen_act) check_ge("R7", "act-to-wr gap", cyc - last_act, TRCD);
                    last_wr = cyc; seen_wr = 1'b1;
                end
                C_PRE: begin
                    last_pre = cyc; seen_pre = 1'b1;
                end
                default: ;
            endcase
        end
    end

    int         got_n;
    logic [2:0] got_cmd [8];
    int         got_row [8];
    int         got_col [8];
    int         got_t   [8];

    task automatic run_req(input bit pol, input bit wr, input bit same, input int row, input int col);
        policy_closed = pol; req_write = wr; req_same_row = same;
        req_row = ROW_W'(row); req_col = COL_W'(col); req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check_eq("R11", "ready cycle after accept", int'(req_ready), 0);
        got_n = 0;
        while (!req_ready) begin
            if (cmd_code != C_NOP && got_n < 8) begin
                got_cmd[got_n] = cmd_code;
                got_row[got_n] = int'(cmd_row);
                got_col[got_n] = int'(cmd_col);
                got_t[got_n]   = cyc;
                got_n++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int wr_stamp, act8_stamp;
        wr_stamp = 0; act8_stamp = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1", "ready after reset", int'(req_ready), 1);
        check_eq("R1", "cmd after reset", int'(cmd_code), 0);
        repeat (4) @(negedge clk);
        check_eq("R11", "idle cmd stays NOP", int'(cmd_code), 0);
        check_eq("R11", "idle ready stays high", int'(req_ready), 1);

        for (int v = 0; v < NVEC; v++) begin
            logic [41:0] e;
            int n, row, col;
            e = VEC[v];
            row = int'(e[38:25]);
            col = int'(e[24:15]);
            n = int'(e[14:12]);
            run_req(e[41], e[40], e[39], row, col);
            check_eq("R3 R4 R5 R6", $sformatf("vec %0d command count", v), got_n, n);
            for (int k = 0; k < 4; k++) begin
                if (k < n && k < got_n) begin
                    logic [2:0] ec;
                    ec = e[11 - 3*k -: 3];
                    check_eq("R3 R4 R5 R6", $sformatf("vec %0d cmd %0d", v, k), int'(got_cmd[k]), int'(ec));
                    if (ec == C_PRE) begin
                        check_eq("R2", $sformatf("vec %0d pre row field", v), got_row[k], 0);
                        check_eq("R2", $sformatf("vec %0d pre col field", v), got_col[k], 0);
                    end else begin
                        check_eq("R2", $sformatf("vec %0d row field", v), got_row[k], row);
                        if (ec != C_ACT)
                            check_eq("R2", $sformatf("vec %0d col field", v), got_col[k], col);
                        else
                            check_eq("R2", $sformatf("vec %0d act col field", v), got_col[k], 0);
                    end
                end
            end
            if (got_n >= 2 && v == 0)
                check_eq("R7", "exact act-to-rd", got_t[1] - got_t[0], TRCD);
            if (got_n >= 1 && v == 2) wr_stamp = got_t[0];
            if (got_n >= 1 && v == 3)
                check_eq("R10", "exact wr-to-rd", got_t[0] - wr_stamp, TWTR);
            if (got_n >= 2 && v == 4)
                check_eq("R8", "exact pre-to-act", got_t[1] - got_t[0], TRP);
            if (got_n >= 1 && v == 8) act8_stamp = got_t[0];
            if (got_n >= 1 && v == 9)
                check_eq("R9", "exact act-to-act", got_t[0] - act8_stamp, TRC);
        end

        // Reset with a row open: tracker must forget it
        run_req(0, 0, 0, 12, 3);
        check_eq("R4", "open row 12 first cmd", int'(got_cmd[0]), int'(C_ACT));
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1", "ready after second reset", int'(req_ready), 1);
        check_eq("R1", "cmd after second reset", int'(cmd_code), 0);
        run_req(0, 0, 0, 12, 4);
        check_eq("R1", "post-reset access count", got_n, 2);
        check_eq("R1", "post-reset first cmd is ACT", int'(got_cmd[0]), int'(C_ACT));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule